// File: doc/BRIEF.md
# Nonvolatile Store/Recall Mode Controller

This block keeps a small static RAM together with a behavioural nonvolatile shadow array and sequences transfers between them. In RAM mode the host port reads and writes the RAM like any synchronous memory. A transfer moves the block into nonvolatile mode. A store first erases the shadow array to all ones and then programs it with the RAM image. A recall first clears the RAM to zero and then copies the shadow image into it. During either transfer the host port is locked out and `busy` stays high.

Transfers have three sources. The first is a command pulse (`cmd_store`, `cmd_recall`). The second is a pending power-up recall flag. This flag is set when reset is released and again whenever `pwr_lost` shows that the supply has fallen below the reset threshold. The pending recall runs once `pwr_ok` shows that the supply is above the switch threshold. The third is an automatic store, which runs when `pwr_ok` falls while no power-up recall is pending. Each phase lasts a fixed number of clock cycles, set by a parameter.

Top module: `nv_xfer_ctrl`

## Requirements
- R1: After synchronous active-low reset, `busy` is 0, `xfer_phase` is 0 (idle), `host_rdata` is 0 and a power-up recall is pending.
- R2: When idle, a host write (`host_en`=1, `host_we`=1) updates the addressed RAM word at the clock edge. A host read (`host_en`=1, `host_we`=0) returns the word on `host_rdata` after the next edge. `host_rdata` is 0 in every cycle after which no read was accepted.
- R3: A started store holds `busy` high for exactly ERASE_CYC+PROG_CYC cycles. Afterwards every shadow word equals the RAM word held when the program phase ended.
- R4: `xfer_phase` encodes idle=0, erase=1, program=2, clear=3, copy=4. A store shows 1 for ERASE_CYC cycles, then 2 for PROG_CYC cycles, then 0.
- R5: A recall holds `busy` high for exactly CLEAR_CYC+COPY_CYC cycles and leaves the RAM equal to the shadow array. The shadow array is never changed by a recall, and recalls may be repeated without limit.
- R6: A recall shows phase 3 for CLEAR_CYC cycles, then 4 for COPY_CYC cycles, then 0.
- R7: While `busy` is high, host writes are ignored and `host_rdata` reads 0.
- R8: The power-up recall is pending after reset and after any cycle with `pwr_lost`=1. It starts, one edge later, in the first idle cycle with `pwr_ok`=1. With nothing pending, a rise of `pwr_ok` starts no transfer.
- R9: A 1-to-0 change of `pwr_ok` while idle and with no recall pending starts a store on the next edge.
- R10: If store and recall requests are present in the same idle cycle, the store runs.
- R11: Command requests that arrive while `busy` is high are discarded and do not run later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data, 0 when no read was accepted |
| nv_addr | input | ADDR_W | Observation address into the shadow array |
| nv_rdata | output | DATA_W | Shadow word at `nv_addr` (combinational) |
| cmd_store | input | 1 | Store command |
| cmd_recall | input | 1 | Recall command |
| pwr_lost | input | 1 | Supply below reset threshold |
| pwr_ok | input | 1 | Supply above switch threshold |
| busy | output | 1 | Transfer in progress |
| xfer_phase | output | 3 | Current phase code |

## Verification
The hardest situation to reach is a second request that lands inside a running transfer. A recall command held during a store must vanish. A pending power-up recall, by contrast, must survive an automatic store and then run later. The bench reaches this by driving `pwr_ok`, `pwr_lost` and the commands at chosen offsets inside a transfer whose length it knows. It traces `xfer_phase` cycle by cycle and afterwards sweeps every RAM and shadow address against patterns computed arithmetically.

// File: rtl/nvx_pkg.sv
package nvx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ERASE = 3'd1,
    PH_PROG  = 3'd2,
    PH_CLEAR = 3'd3,
    PH_COPY  = 3'd4
  } phase_t;

  // successor of each phase in the two fixed sequences
  function automatic phase_t next_phase(phase_t p);
    case (p)
      PH_ERASE: next_phase = PH_PROG;
      PH_CLEAR: next_phase = PH_COPY;
      default:  next_phase = PH_IDLE;
    endcase
  endfunction

  // duration of a phase in clock cycles
  function automatic int unsigned phase_len(phase_t p, int unsigned e, int unsigned pr,
                                            int unsigned c, int unsigned cp);
    case (p)
      PH_ERASE: phase_len = e;
      PH_PROG:  phase_len = pr;
      PH_CLEAR: phase_len = c;
      PH_COPY:  phase_len = cp;
      default:  phase_len = 1;
    endcase
  endfunction

  function automatic int unsigned max4(int unsigned a, int unsigned b, int unsigned c,
                                       int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    max4 = m;
  endfunction

endpackage

// File: rtl/nvx_trigger.sv
module nvx_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_store,
  input  logic cmd_recall,
  input  logic pwr_lost,
  input  logic pwr_ok,
  input  logic busy,
  output logic start_store,
  output logic start_recall,
  output logic pu_pend,
  output logic auto_fall
);
  logic pwr_ok_q;
  logic want_store;
  logic want_recall;

  // falling supply flag, only once the power-up recall has been served
  assign auto_fall   = pwr_ok_q & ~pwr_ok & ~pu_pend;
  assign want_store  = cmd_store | auto_fall;
  assign want_recall = cmd_recall | (pu_pend & pwr_ok);

  // store has priority; nothing starts while a transfer runs
  assign start_store  = want_store & ~busy;
  assign start_recall = want_recall & ~want_store & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_ok_q <= 1'b0;
      pu_pend  <= 1'b1;
    end else begin
      pwr_ok_q <= pwr_ok;
      if (pwr_lost)          pu_pend <= 1'b1;
      else if (start_recall) pu_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/nvx_sequencer.sv
module nvx_sequencer
  import nvx_pkg::*;
#(
  parameter int unsigned ERASE_CYC = 4,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned CLEAR_CYC = 4,
  parameter int unsigned COPY_CYC  = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_store,
  input  logic   start_recall,
  output phase_t phase,
  output logic   busy,
  output logic   phase_done
);
  localparam int unsigned MAXC  = max4(ERASE_CYC, PROG_CYC, CLEAR_CYC, COPY_CYC);
  localparam int unsigned CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  logic [CNT_W-1:0] cnt;
  phase_t           nxt;

  function automatic logic [CNT_W-1:0] load_of(phase_t p);
    load_of = CNT_W'(phase_len(p, ERASE_CYC, PROG_CYC, CLEAR_CYC, COPY_CYC) - 1);
  endfunction

  assign busy       = (phase != PH_IDLE);
  assign phase_done = busy && (cnt == '0);
  assign nxt        = next_phase(phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (!busy) begin
      if (start_store) begin
        phase <= PH_ERASE;
        cnt   <= load_of(PH_ERASE);
      end else if (start_recall) begin
        phase <= PH_CLEAR;
        cnt   <= load_of(PH_CLEAR);
      end
    end else if (phase_done) begin
      phase <= nxt;
      cnt   <= (nxt == PH_IDLE) ? '0 : load_of(nxt);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nvx_arrays.sv
module nvx_arrays
  import nvx_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          busy,
  input  logic                          phase_done,
  input  phase_t                        phase,
  input  logic                          host_en,
  input  logic                          host_we,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic [DATA_W-1:0]             host_wdata,
  output logic [DATA_W-1:0]             host_rdata,
  input  logic [ADDR_W-1:0]             nv_addr,
  output logic [DATA_W-1:0]             nv_rdata,
  output logic [2**ADDR_W-1:0][DATA_W-1:0] nv_img
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] ram;
  logic                         rd_ok;
  logic                         wr_ok;

  assign rd_ok    = host_en & ~host_we & ~busy;
  assign wr_ok    = host_en & host_we & ~busy;
  assign nv_rdata = nv_img[nv_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram        <= '0;
      nv_img     <= '1;
      host_rdata <= '0;
    end else begin
      host_rdata <= rd_ok ? ram[host_addr] : '0;
      if (wr_ok) ram[host_addr] <= host_wdata;
      if (phase_done) begin
        case (phase)
          PH_ERASE: nv_img <= '1;
          PH_PROG:  nv_img <= ram;
          PH_CLEAR: ram    <= '0;
          PH_COPY:  ram    <= nv_img;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nv_xfer_ctrl.sv
module nv_xfer_ctrl
  import nvx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ERASE_CYC = 64,
  parameter int unsigned PROG_CYC  = 256,
  parameter int unsigned CLEAR_CYC = 16,
  parameter int unsigned COPY_CYC  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [ADDR_W-1:0] nv_addr,
  output logic [DATA_W-1:0] nv_rdata,
  input  logic              cmd_store,
  input  logic              cmd_recall,
  input  logic              pwr_lost,
  input  logic              pwr_ok,
  output logic              busy,
  output logic [2:0]        xfer_phase
);
  logic   start_store;
  logic   start_recall;
  logic   pu_pend;
  logic   auto_fall;
  logic   phase_done;
  phase_t phase;
  logic [2**ADDR_W-1:0][DATA_W-1:0] nv_img;

  assign xfer_phase = phase;

  nvx_trigger u_trig (
    .clk(clk), .rst_n(rst_n),
    .cmd_store(cmd_store), .cmd_recall(cmd_recall),
    .pwr_lost(pwr_lost), .pwr_ok(pwr_ok), .busy(busy),
    .start_store(start_store), .start_recall(start_recall),
    .pu_pend(pu_pend), .auto_fall(auto_fall)
  );

  nvx_sequencer #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
    .CLEAR_CYC(CLEAR_CYC), .COPY_CYC(COPY_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_store(start_store), .start_recall(start_recall),
    .phase(phase), .busy(busy), .phase_done(phase_done)
  );

  nvx_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .busy(busy), .phase_done(phase_done), .phase(phase),
    .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .nv_addr(nv_addr), .nv_rdata(nv_rdata), .nv_img(nv_img)
  );
endmodule

// File: rtl/nvx_checker.sv
module nvx_checker
  import nvx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ERASE_CYC = 4,
  parameter int unsigned PROG_CYC  = 4,
  parameter int unsigned CLEAR_CYC = 4,
  parameter int unsigned COPY_CYC  = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input phase_t                           phase,
  input logic                             busy,
  input logic [DATA_W-1:0]                host_rdata,
  input logic                             cmd_store,
  input logic                             cmd_recall,
  input logic                             pwr_ok,
  input logic                             pu_pend,
  input logic                             start_store,
  input logic                             start_recall,
  input logic [2**ADDR_W-1:0][DATA_W-1:0] nv_img
);
  phase_t      prev_ph;
  int unsigned run;

  // length of the run of equal phase values that ended at prev_ph
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ph <= PH_IDLE;
      run     <= 0;
    end else begin
      prev_ph <= phase;
      run     <= (phase != prev_ph) ? 1 : run + 1;
    end
  end

  assert_erase_then_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ph == PH_ERASE && phase != PH_ERASE) |-> phase == PH_PROG);
  assert_erase_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ph == PH_ERASE && phase != PH_ERASE) |-> run == ERASE_CYC);
  assert_prog_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ph == PH_PROG && phase != PH_PROG) |-> (run == PROG_CYC && phase == PH_IDLE));
  assert_clear_then_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ph == PH_CLEAR && phase != PH_CLEAR) |-> (phase == PH_COPY && run == CLEAR_CYC));
  assert_copy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ph == PH_COPY && phase != PH_COPY) |-> (run == COPY_CYC && phase == PH_IDLE));
  assert_recall_keeps_nv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLEAR || phase == PH_COPY) |=> $stable(nv_img));
  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> host_rdata == '0);
  assert_store_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_store && cmd_recall && !busy) |=> phase == PH_ERASE);
  assert_pu_recall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_pend && pwr_ok && !busy && !cmd_store) |=> phase == PH_CLEAR);
  assert_autostore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_ok) && !pwr_ok && !busy && !pu_pend) |=> phase == PH_ERASE);
  assert_start_needs_trigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_store || start_recall));
endmodule

bind nv_xfer_ctrl nvx_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
  .CLEAR_CYC(CLEAR_CYC), .COPY_CYC(COPY_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .busy(busy), .host_rdata(host_rdata),
  .cmd_store(cmd_store), .cmd_recall(cmd_recall), .pwr_ok(pwr_ok), .pu_pend(pu_pend),
  .start_store(start_store), .start_recall(start_recall), .nv_img(nv_img)
);

// File: tb/test_nv_xfer_ctrl.sv
`timescale 1ns/1ps
module test_nv_xfer_ctrl;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DEPTH = 2 ** AW;
  localparam int E = 3, P = 4, C = 2, CP = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_en = 0, host_we = 0, cmd_store = 0, cmd_recall = 0, pwr_lost = 0, pwr_ok = 0;
  logic [AW-1:0] host_addr = '0, nv_addr = '0;
  logic [DW-1:0] host_wdata = '0, host_rdata, nv_rdata;
  logic busy;
  logic [2:0] xfer_phase;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nv_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYC(E), .PROG_CYC(P),
                 .CLEAR_CYC(C), .COPY_CYC(CP)) i_nv_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .nv_addr(nv_addr), .nv_rdata(nv_rdata), .cmd_store(cmd_store),
    .cmd_recall(cmd_recall), .pwr_lost(pwr_lost), .pwr_ok(pwr_ok),
    .busy(busy), .xfer_phase(xfer_phase));

  function automatic logic [DW-1:0] pat_a(int a); return DW'((a * 29 + 7) % 256); endfunction
  function automatic logic [DW-1:0] pat_b(int a); return DW'((a * 53 + 200) % 256); endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    host_en = 1; host_we = 1; host_addr = AW'(a); host_wdata = DW'(d);
    @(negedge clk);
    host_en = 0; host_we = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    host_en = 1; host_we = 0; host_addr = AW'(a);
    @(negedge clk);
    chk(host_rdata == DW'(exp), tag, host_rdata, exp);
    host_en = 0;
  endtask

  task automatic nv_chk(input int a, input int exp, input string tag);
    nv_addr = AW'(a);
    #1;
    chk(nv_rdata == DW'(exp), tag, nv_rdata, exp);
  endtask

  // called right after a trigger is driven at a falling edge
  task automatic trace(input int c1, input int l1, input int c2, input int l2, input string tag);
    for (int i = 0; i < l1 + l2; i++) begin
      @(negedge clk);
      if (i == 0) begin cmd_store = 0; cmd_recall = 0; end
      chk(busy && xfer_phase == 3'((i < l1) ? c1 : c2), tag, xfer_phase, (i < l1) ? c1 : c2);
    end
    @(negedge clk);
    chk(!busy && xfer_phase == 3'd0, tag, {busy, xfer_phase}, 0);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && xfer_phase == 0 && host_rdata == 0, "R1 reset state",
        {busy, xfer_phase, host_rdata}, 0);
    // R8: pending power-up recall waits for pwr_ok
    repeat (2) @(negedge clk);
    chk(!busy, "R8 no recall while pwr_ok low", busy, 0);
    pwr_ok = 1;
    trace(3, C, 4, CP, "R8 power-up recall R6");
    for (int a = 0; a < DEPTH; a++) rd_chk(a, 8'hFF, "R5 recall of erased array");

    // R2 RAM mode sweep
    for (int a = 0; a < DEPTH; a++) wr(a, pat_a(a));
    for (int a = 0; a < DEPTH; a++) rd_chk(a, pat_a(a), "R2 read back");
    @(negedge clk);
    chk(host_rdata == 0, "R2 idle rdata", host_rdata, 0);

    // R3/R4 command store
    cmd_store = 1;
    trace(1, E, 2, P, "R4 store phases R3");
    for (int a = 0; a < DEPTH; a++) nv_chk(a, pat_a(a), "R3 shadow programmed");

    // R5/R6 recall restores, repeated
    for (int a = 0; a < DEPTH; a++) wr(a, pat_b(a));
    for (int a = 0; a < DEPTH; a++) rd_chk(a, pat_b(a), "R2 overwrite");
    for (int n = 0; n < 2; n++) begin
      cmd_recall = 1;
      trace(3, C, 4, CP, "R6 recall phases R5");
      for (int a = 0; a < DEPTH; a++) rd_chk(a, pat_a(a), "R5 ram restored");
      for (int a = 0; a < DEPTH; a++) nv_chk(a, pat_a(a), "R5 shadow unchanged");
    end

    // R7 lockout
    cmd_store = 1;
    @(negedge clk);
    cmd_store = 0;
    host_en = 1; host_we = 1; host_addr = 0; host_wdata = ~pat_a(0);
    @(negedge clk);
    host_we = 0;
    @(negedge clk);
    chk(busy && host_rdata == 0, "R7 read blocked", host_rdata, 0);
    host_en = 0;
    wait_idle();
    @(negedge clk);
    rd_chk(0, pat_a(0), "R7 write ignored");

    // R11 command during busy discarded
    cmd_store = 1;
    @(negedge clk);
    cmd_store = 0; cmd_recall = 1;
    repeat (3) @(negedge clk);
    cmd_recall = 0;
    wait_idle();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy, "R11 late recall dropped", busy, 0);
    end

    // R10 simultaneous requests
    for (int a = 0; a < DEPTH; a++) wr(a, pat_b(a));
    cmd_store = 1; cmd_recall = 1;
    trace(1, E, 2, P, "R10 store wins");
    for (int a = 0; a < DEPTH; a++) nv_chk(a, pat_b(a), "R10 shadow has store data");

    // R9 autostore on falling pwr_ok
    wr(1, 8'h3C);
    pwr_ok = 0;
    trace(1, E, 2, P, "R9 autostore");
    nv_chk(1, 8'h3C, "R9 shadow updated");

    // R8 no recall without pending flag
    pwr_ok = 1;
    repeat (3) @(negedge clk);
    chk(!busy, "R8 no recall without pending", busy, 0);
    pwr_ok = 0;
    @(negedge clk);
    wait_idle();
    pwr_lost = 1;
    @(negedge clk);
    pwr_lost = 0;
    wr(2, 8'h11);
    pwr_ok = 1;
    trace(3, C, 4, CP, "R8 recall after supply loss");
    rd_chk(2, pat_b(2), "R8 ram recalled");
    rd_chk(1, 8'h3C, "R8 ram recalled");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule